// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block walks one external bus transaction through a fixed chain of clock phases: T0, T1, T2 and T3. It can stretch the transaction with wait states. Each wait adds a TW phase followed by a repeated T2. A slow target asks for waits by holding an active-low acknowledge input high. A programmed wait count can also impose a minimum number of waits. The count that is inserted is the larger of these two requests.

The acknowledge input is looked at only in T0 and in every T2. In all other phases, and while no transaction runs, it has no effect. Acknowledge low during T0 together with a programmed count of zero gives a zero-wait shortcut: the transaction then ends after its first T2, whatever acknowledge does there. The programmed count is taken once, during T0, and holds for the rest of the transaction.

A start request that is present during T3 chains the next transaction directly into T0, with no idle phase between them. The block drives three outputs. A bus strobe marks every phase of an active transaction. A phase code shows where the sequencer stands. A one-clock done flag marks T3.

Top module: `xbus_wait_seq`

## Requirements
- R1: A synchronous reset returns the sequencer to idle in the next cycle. Idle shows phase_code 0, with bus_strobe low and cycle_done low. The reset may arrive in the middle of a transaction.
- R2: A start_req that is high while idle makes the next cycle T0 (code 1), followed by T1 (code 2) and then T2 (code 3). bus_strobe is high in every non-idle phase, which is the active-high default.
- R3: Suppose acknowledge is low in T2, the programmed count is 0 and no shortcut is pending. The following phase is T3 (code 5), so the transaction is T0 T1 T2 T3 with zero waits.
- R4: Each T2 in which ack_n is high, with no shortcut pending, is followed by TW (code 4) and then by T2 again. There is no upper limit on the number of waits; 20 waits in a row are exercised.
- R5: While fewer waits than the programmed count have been inserted, T2 is followed by TW whatever the state of acknowledge. With acknowledge low from the first T2 on, the wait count equals the programmed count (tested for 3 and 15).
- R6: Acknowledge must be low in the T2 that ends the programmed length, or waits continue. Take a programmed count of 2 with ack_n high in the first three T2 phases: this gives 3 waits.
- R7: Suppose ack_n is low during T0 and the programmed count is 0. The transaction then has zero waits even with ack_n high in T2.
- R8: wait_cfg is sampled only during T0. Changing it later in the transaction has no effect; moving it from 2 to 9 after T0 still gives 2 waits.
- R9: cycle_done is high for exactly the T3 cycle. If start_req is high during T3, the next cycle is T0; otherwise the next cycle is idle.
- R10: While idle with start_req low, toggling ack_n keeps the phase idle and bus_strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Request to begin a transaction |
| ack_n | input | 1 | Transfer acknowledge, active low |
| wait_cfg | input | WCW (4) | Programmed minimum wait count |
| bus_strobe | output | 1 | High during every phase of an active transaction |
| phase_code | output | 3 | 0 idle, 1 T0, 2 T1, 3 T2, 4 TW, 5 T3 |
| cycle_done | output | 1 | High during T3 |

## Verification
Each output follows from the inputs of one cycle, one clock later. The inputs present while a phase is shown decide the phase of the next cycle, and that next phase is visible after one rising edge. The bench drives its inputs on the falling edge. On every falling edge it first compares the outputs with a behavioural model that was stepped on the preceding rising edge. Apart from this per-cycle comparison, each transaction's count of TW phases is checked against a value worked out by hand from R3 to R8.

// File: rtl/xbw_pkg.sv
package xbw_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T0   = 3'd1,
      PH_T1   = 3'd2,
      PH_T2   = 3'd3,
      PH_TW   = 3'd4,
      PH_T3   = 3'd5
   } xbw_phase_e;
endpackage

// File: rtl/xbw_cfg_latch.sv
module xbw_cfg_latch #(
   parameter int WCW = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_t0,
   input  logic           ack_n,
   input  logic [WCW-1:0] wait_cfg,
   output logic [WCW-1:0] cfg_q,
   output logic           zero_short
);
   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q      <= '0;
         zero_short <= 1'b0;
      end else if (in_t0) begin
         cfg_q      <= wait_cfg;
         zero_short <= !ack_n && (wait_cfg == '0);
      end
   end
endmodule

// File: rtl/xbw_wait_ctr.sv
module xbw_wait_ctr #(
   parameter int WCW = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           clr,
   input  logic           inc,
   output logic [WCW-1:0] waits
);
   localparam logic [WCW-1:0] SAT = {WCW{1'b1}};

   always_ff @(posedge clk) begin
      if (rst || clr)
         waits <= '0;
      else if (inc && waits != SAT)
         waits <= waits + 1'b1;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (waits == SAT && inc && !clr) |=> (waits == SAT)); // R4
endmodule

// File: rtl/xbw_phase_fsm.sv
module xbw_phase_fsm
   import xbw_pkg::*;
#(
   parameter int WCW = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start_req,
   input  logic           ack_n,
   input  logic [WCW-1:0] cfg_q,
   input  logic           zero_short,
   input  logic [WCW-1:0] waits,
   output xbw_phase_e     ph,
   output logic           in_t0,
   output logic           ctr_clr,
   output logic           ctr_inc
);
   xbw_phase_e nxt;
   logic       exit_t2;

   assign exit_t2 = zero_short || (!ack_n && (waits >= cfg_q));

   always_comb begin
      nxt = ph;
      unique case (ph)
         PH_IDLE: nxt = start_req ? PH_T0 : PH_IDLE;
         PH_T0:   nxt = PH_T1;
         PH_T1:   nxt = PH_T2;
         PH_T2:   nxt = exit_t2 ? PH_T3 : PH_TW;
         PH_TW:   nxt = PH_T2;
         PH_T3:   nxt = start_req ? PH_T0 : PH_IDLE;
         default: nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) ph <= PH_IDLE;
      else     ph <= nxt;
   end

   assign in_t0   = (ph == PH_T0);
   assign ctr_clr = (ph == PH_T0);
   assign ctr_inc = (ph == PH_T2) && !exit_t2;

   AST_T0_TO_T1: assert property (@(posedge clk) disable iff (rst)
      (ph == PH_T0) |=> (ph == PH_T1)); // R2
   AST_NOWAIT_EXIT: assert property (@(posedge clk) disable iff (rst)
      (ph == PH_T2 && !ack_n && waits >= cfg_q) |=> (ph == PH_T3)); // R3
   AST_TW_TO_T2: assert property (@(posedge clk) disable iff (rst)
      (ph == PH_TW) |=> (ph == PH_T2)); // R4
   AST_MIN_WAIT: assert property (@(posedge clk) disable iff (rst)
      (ph == PH_T2 && !zero_short && waits < cfg_q) |=> (ph == PH_TW)); // R5
   AST_ACK_HIGH_WAIT: assert property (@(posedge clk) disable iff (rst)
      (ph == PH_T2 && !zero_short && ack_n) |=> (ph == PH_TW)); // R6
   AST_SHORT_EXIT: assert property (@(posedge clk) disable iff (rst)
      (ph == PH_T2 && zero_short) |=> (ph == PH_T3)); // R7
   AST_CHAIN: assert property (@(posedge clk) disable iff (rst)
      (ph == PH_T3 && start_req) |=> (ph == PH_T0)); // R9
endmodule

// File: rtl/xbus_wait_seq.sv
module xbus_wait_seq
   import xbw_pkg::*;
#(
   parameter int WCW            = 4,
   parameter bit STROBE_ACT_LOW = 1'b0
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start_req,
   input  logic           ack_n,
   input  logic [WCW-1:0] wait_cfg,
   output logic           bus_strobe,
   output logic [2:0]     phase_code,
   output logic           cycle_done
);
   generate
      if (WCW < 1 || WCW > 8) begin : g_bad_wcw
         $error("xbus_wait_seq: WCW must lie in 1..8");
      end
   endgenerate

   xbw_phase_e     ph;
   logic           in_t0, ctr_clr, ctr_inc, zero_short;
   logic [WCW-1:0] cfg_q, waits;

   xbw_cfg_latch #(.WCW(WCW)) u_cfg (
      .clk(clk), .rst(rst), .in_t0(in_t0), .ack_n(ack_n),
      .wait_cfg(wait_cfg), .cfg_q(cfg_q), .zero_short(zero_short)
   );

   xbw_wait_ctr #(.WCW(WCW)) u_ctr (
      .clk(clk), .rst(rst), .clr(ctr_clr), .inc(ctr_inc), .waits(waits)
   );

   xbw_phase_fsm #(.WCW(WCW)) u_fsm (
      .clk(clk), .rst(rst), .start_req(start_req), .ack_n(ack_n),
      .cfg_q(cfg_q), .zero_short(zero_short), .waits(waits),
      .ph(ph), .in_t0(in_t0), .ctr_clr(ctr_clr), .ctr_inc(ctr_inc)
   );

   logic active;
   assign active = (ph != PH_IDLE);

   generate
      if (STROBE_ACT_LOW) begin : g_strobe_low
         assign bus_strobe = !active;
      end else begin : g_strobe_high
         assign bus_strobe = active;
      end
   endgenerate

   assign phase_code = ph;
   assign cycle_done = (ph == PH_T3);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      cycle_done |=> !cycle_done); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (phase_code == 3'd0 && !start_req) |=> (phase_code == 3'd0)); // R10
   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (phase_code == 3'd0 && !cycle_done)); // R1
endmodule

// File: tb/sim_xbus_wait_seq.sv
`timescale 1ns/1ps
module sim_xbus_wait_seq;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start_req = 1'b0;
   logic       ack_n = 1'b1;
   logic [3:0] wait_cfg = 4'd0;
   logic       bus_strobe;
   logic [2:0] phase_code;
   logic       cycle_done;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   always #2 clk = ~clk;

   xbus_wait_seq u0 (
      .clk(clk), .rst(rst), .start_req(start_req), .ack_n(ack_n),
      .wait_cfg(wait_cfg), .bus_strobe(bus_strobe),
      .phase_code(phase_code), .cycle_done(cycle_done)
   );

   // behavioural reference: 0 idle,1 T0,2 T1,3 T2,4 TW,5 T3
   int m_ph = 0, m_w = 0, m_cfg = 0;
   bit m_short = 0;
   always @(posedge clk) begin
      if (rst) m_ph = 0;
      else begin
         case (m_ph)
            0: if (start_req) m_ph = 1;
            1: begin
                  m_cfg = wait_cfg; m_w = 0;
                  m_short = (ack_n == 1'b0) && (wait_cfg == 0);
                  m_ph = 2;
               end
            2: m_ph = 3;
            3: if (m_short || (!ack_n && m_w >= m_cfg)) m_ph = 5;
               else begin m_ph = 4; m_w++; end
            4: m_ph = 3;
            5: m_ph = start_req ? 1 : 0;
            default: m_ph = 0;
         endcase
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step_cmp(input string tag);
      @(negedge clk);
      check(phase_code == m_ph[2:0], tag, phase_code, m_ph);
      check(bus_strobe == (m_ph != 0), "R2 strobe", bus_strobe, m_ph != 0);
      check(cycle_done == (m_ph == 5), "R9 done", cycle_done, m_ph == 5);
   endtask

   task automatic run_cycle(input int cfg, input bit ack0_low, input int nhigh,
                            input int cfg_late, input bit chain, input int exp_w,
                            input string tag);
      int  t2 = 0;
      int  dw = 0;
      bit  fin = 0;
      while (!fin) begin
         step_cmp(tag);
         if (phase_code == 3'd4) dw++;
         case (m_ph)
            0: start_req = 1'b1;
            1: begin
                  start_req = 1'b0;
                  wait_cfg  = cfg[3:0];
                  ack_n     = ack0_low ? 1'b0 : 1'b1;
               end
            3: begin
                  ack_n    = (t2 < nhigh) ? 1'b1 : 1'b0;
                  t2++;
                  wait_cfg = cfg_late[3:0];
               end
            5: begin
                  start_req = chain;
                  ack_n     = 1'b1;
                  fin       = 1;
               end
            default: begin
                  ack_n    = 1'b1;
                  wait_cfg = cfg_late[3:0];
               end
         endcase
      end
      check(dw == exp_w, {tag, " wait count"}, dw, exp_w);
   endtask

   initial begin
      #(200000 * 4);
      if (!ended) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      step_cmp("R1 reset state");
      check(phase_code == 3'd0, "R1 idle after reset", phase_code, 0);

      // R10: acknowledge toggling while idle
      for (int i = 0; i < 6; i++) begin
         ack_n = ~ack_n;
         step_cmp("R10 idle ignores ack");
         check(bus_strobe == 1'b0, "R10 strobe low", bus_strobe, 0);
      end
      ack_n = 1'b1;

      run_cycle(0, 0, 0, 0, 0, 0,  "R3 zero wait");
      run_cycle(1, 1, 4, 1, 0, 4,  "R4 handshake waits");
      run_cycle(0, 0, 20, 0, 0, 20, "R4 long waits");
      run_cycle(3, 0, 0, 3, 0, 3,  "R5 programmed waits");
      run_cycle(15, 0, 0, 15, 0, 15, "R5 max programmed");
      run_cycle(2, 0, 3, 2, 0, 3,  "R6 late ack");
      run_cycle(0, 1, 5, 0, 0, 0,  "R7 shortcut");
      run_cycle(2, 0, 0, 9, 0, 2,  "R8 cfg ignored after T0");
      run_cycle(1, 0, 0, 1, 1, 1,  "R9 chain first");
      run_cycle(0, 0, 2, 0, 0, 2,  "R9 chain second");
      step_cmp("R9 idle after T3");
      check(phase_code == 3'd0, "R9 no start gives idle", phase_code, 0);

      // R1: reset in the middle of a transaction
      start_req = 1'b1;
      step_cmp("R1 pre");
      start_req = 1'b0;
      while (m_ph != 3) step_cmp("R1 pre");
      rst = 1'b1;
      step_cmp("R1 mid reset");
      check(phase_code == 3'd0, "R1 mid reset idle", phase_code, 0);
      check(bus_strobe == 1'b0, "R1 mid reset strobe", bus_strobe, 0);
      rst = 1'b0;
      step_cmp("R1 after reset");

      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule